// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block judges one executing load against the stores that are older than it and have not yet left the store queue for memory. It reads every store-queue slot in parallel. It walks the window of pending older stores from the youngest one back to the writeback pointer. It returns exactly one verdict per load, one cycle later:
- **forward:** a store's bytes fully cover the load, so its data is returned.
- **replay:** a store covers only some of the load's bytes, so the load must be reissued.
- **miss:** no pending store touches the load, so it goes to the data cache.

The block also holds two pieces of state:
- **Stall record.** It keeps the oldest load that was replayed for a partial overlap, and the store that load waits on. The surrounding pipeline clears this record once that store drains.
- **Blocked-load record.** It keeps the oldest load that found the cache unable to accept a request.

An uncacheable load is scanned only when it sits at the load-queue head and has reached the commit point. Otherwise it is turned back for rescheduling.

Top module: `stlf_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to zero after that edge.
- R2: The stores examined are the slots from `req_sq_idx - 1` down to `sq_wb_ptr` inclusive, taken modulo the queue depth. That is (`req_sq_idx - sq_wb_ptr`) mod depth slots, and none when the two are equal. Slots outside that window have no effect.
- R3: A slot whose size is zero (address not yet known) or whose uncacheable flag is set is skipped. The scan continues past it.
- R4: Each store occupies the byte range [addr, addr+size) and the load occupies [addr, addr+size); sizes are byte counts. A store fully contains the load when the load's start is not below the store's start and the load's end is not above the store's end. Scanning youngest first, the first store that overlaps the load decides the verdict, whether it contains the load or only overlaps it.
- R5: On a forward, the offset is the load address ANDed with (store size - 1). Byte i of `fwd_data`, at bits [8i+7:8i], is store data byte (offset + i) for i below the load size, and zero above it.
- R6: When the deciding store only partly overlaps the load, the response is `replay_valid` = 1 with `replay_partial` = 1 and `replay_store_seq` = that store's sequence number. There is no forward and no cache request.
- R7: A partial-overlap replay writes the stall record (`stalled`, `stall_store_seq`, `stall_load_idx`) in two cases: when no stall is recorded, or when the load's sequence number is below that of the recorded stalling load. Otherwise the record is kept. `stall_release` clears the record, and a replay in the same cycle then records freshly.
- R8: An uncacheable load whose `req_lq_idx` differs from `lq_head`, or that has `req_at_commit` low, gets `replay_valid` = 1 with `replay_partial` = 0. It does not scan and does not touch the stall record. An uncacheable load at the head and at commit is judged like any other load.
- R9: When no store overlaps the load and `cache_blocked` is low, `mem_req_valid` pulses with the load's address and size.
- R10: When no store overlaps the load and `cache_blocked` is high, `miss_refused` pulses and no cache request is made. The blocked record (`ld_blocked`, `ld_blocked_seq`) takes the load's sequence number unless a blocked load with a smaller sequence number is already held. `blk_release` clears the record first.
- R11: Every request accepted at a clock edge yields exactly one of `fwd_valid`, `replay_valid`, `mem_req_valid`, `miss_refused` during the next cycle. With no request, none of them is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A load is presented this cycle |
| req_addr | input | ADDR_W | Load byte address |
| req_size | input | SZ_W | Load size in bytes (1..DATA_BYTES) |
| req_sq_idx | input | PTR_W | Store-queue position recorded for the load at dispatch |
| req_lq_idx | input | LQ_W | Load-queue slot of the load |
| req_seq | input | SEQ_W | Load sequence number (smaller is older) |
| req_uncache | input | 1 | Load is uncacheable |
| req_at_commit | input | 1 | Load has reached the commit point |
| lq_head | input | LQ_W | Current load-queue head slot |
| sq_wb_ptr | input | PTR_W | Oldest store not yet written to memory |
| sq_addr | input | SQ_DEPTH*ADDR_W | Per-slot store address, slot j at [j*ADDR_W +: ADDR_W] |
| sq_size | input | SQ_DEPTH*SZ_W | Per-slot store size in bytes, 0 = address unknown |
| sq_data | input | SQ_DEPTH*DATA_BYTES*8 | Per-slot store data, byte 0 lowest |
| sq_seq | input | SQ_DEPTH*SEQ_W | Per-slot store sequence number |
| sq_uncache | input | SQ_DEPTH | Per-slot uncacheable flag |
| cache_blocked | input | 1 | Data cache cannot accept a request |
| stall_release | input | 1 | Clear the stall record |
| blk_release | input | 1 | Clear the blocked-load record |
| fwd_valid | output | 1 | Forwarded data valid |
| fwd_data | output | DATA_BYTES*8 | Forwarded load bytes, zero above the load size |
| replay_valid | output | 1 | Load must be rescheduled |
| replay_partial | output | 1 | 1 = partial overlap, 0 = uncacheable away from head |
| replay_store_seq | output | SEQ_W | Sequence number of the blocking store |
| mem_req_valid | output | 1 | Send the load to the cache |
| mem_req_addr | output | ADDR_W | Cache request address |
| mem_req_size | output | SZ_W | Cache request size |
| miss_refused | output | 1 | Miss that found the cache blocked |
| stalled | output | 1 | A partial-overlap stall is recorded |
| stall_store_seq | output | SEQ_W | Store the stalled load waits on |
| stall_load_idx | output | LQ_W | Load-queue slot of the stalled load |
| ld_blocked | output | 1 | A cache-blocked load is recorded |
| ld_blocked_seq | output | SEQ_W | Sequence number of that load |

## Verification
The stall and blocked records are visible on the ports. A wrong update to either one therefore shows in the cycle after the offending request, and it keeps showing until a release. A mistake in the window bounds or in the youngest-first priority shows up one cycle after the request as the wrong verdict, or as forwarded bytes from the wrong slot. Wrong offset arithmetic corrupts `fwd_data` in that same cycle. The stimulus places stores at the writeback pointer, just outside it, and stacked on the same bytes, so that each of these faults changes a sampled verdict.

// File: rtl/stlf_pkg.sv
// Shared types for the store-to-load forwarding checker.
// Assumes nothing beyond the users agreeing on the verdict encoding.
package stlf_pkg;

    // Verdict of the youngest-first scan over the pending older stores.
    typedef enum logic [1:0] {
        SCAN_MISS = 2'd0,
        SCAN_FULL = 2'd1,
        SCAN_PART = 2'd2
    } scan_kind_e;

endpackage

// File: rtl/stlf_overlap.sv
// Compares one store slot against the load's byte range.
// Ranges are half-open [addr, addr+size). The arithmetic is one bit wider
// than the address so that an end at the top of the space does not wrap.
// A slot with size zero or with its uncacheable flag set never matches.
module stlf_overlap #(
    parameter int ADDR_W = 16,
    parameter int SZ_W   = 4
) (
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZ_W-1:0]   st_size,
    input  logic              st_uncache,
    output logic              full,
    output logic              part
);

    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] ld_s, ld_e, st_s, st_e;
    logic             usable, covers, touches;

    // Range ends and the containment / intersection tests.
    always_comb begin
        ld_s    = {1'b0, ld_addr};
        ld_e    = ld_s + EXT_W'(ld_size);
        st_s    = {1'b0, st_addr};
        st_e    = st_s + EXT_W'(st_size);
        usable  = (st_size != '0) && !st_uncache;
        covers  = (ld_s >= st_s) && (ld_e <= st_e);
        touches = (ld_s < st_e) && (ld_e > st_s);
        full    = usable && covers;
        part    = usable && touches && !covers;
    end

endmodule

// File: rtl/stlf_select.sv
// Walks the pending window youngest first and reports the first slot that
// overlaps the load. The window is sq_idx-1 down to wb_ptr inclusive,
// modulo the depth. It assumes SQ_DEPTH is a power of two, so that the
// pointer subtraction wraps naturally.
module stlf_select
    import stlf_pkg::*;
#(
    parameter int SQ_DEPTH = 8,
    parameter int PTR_W    = $clog2(SQ_DEPTH)
) (
    input  logic [SQ_DEPTH-1:0] full,
    input  logic [SQ_DEPTH-1:0] part,
    input  logic [PTR_W-1:0]    sq_idx,
    input  logic [PTR_W-1:0]    wb_ptr,
    output scan_kind_e          kind,
    output logic [PTR_W-1:0]    hit_idx
);

    logic [PTR_W-1:0] span;
    logic [PTR_W-1:0] slot;
    logic             found;

    // Priority scan: the first overlapping slot from the youngest side decides.
    always_comb begin
        span    = sq_idx - wb_ptr;
        kind    = SCAN_MISS;
        hit_idx = '0;
        found   = 1'b0;
        slot    = '0;
        for (int k = 0; k < SQ_DEPTH; k++) begin
            slot = sq_idx - PTR_W'(k + 1);
            if (!found && (PTR_W'(k) < span)) begin
                if (full[slot]) begin
                    kind    = SCAN_FULL;
                    hit_idx = slot;
                    found   = 1'b1;
                end else if (part[slot]) begin
                    kind    = SCAN_PART;
                    hit_idx = slot;
                    found   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/stlf_extract.sv
// Picks the load's bytes out of a store's data.
// The offset is the load address masked by (store size - 1). It assumes
// stores are naturally aligned and that the store size is a power of two
// no larger than DATA_BYTES. Bytes above the load size are zero.
module stlf_extract #(
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 8,
    parameter int SZ_W       = $clog2(DATA_BYTES) + 1
) (
    input  logic [DATA_BYTES*8-1:0] st_data,
    input  logic [SZ_W-1:0]         st_size,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [SZ_W-1:0]         ld_size,
    output logic [DATA_BYTES*8-1:0] data
);

    localparam int OFF_W = $clog2(DATA_BYTES);

    logic [SZ_W-1:0]  size_mask;
    logic [OFF_W-1:0] offset;

    // Byte steering: output byte i takes store byte (offset + i).
    always_comb begin
        size_mask = st_size - 1'b1;
        offset    = ld_addr[OFF_W-1:0] & size_mask[OFF_W-1:0];
        data      = '0;
        for (int i = 0; i < DATA_BYTES; i++) begin
            for (int j = 0; j < DATA_BYTES; j++) begin
                if ((int'(offset) + i == j) && (i < int'(ld_size))) begin
                    data[i*8 +: 8] = st_data[j*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/stlf_checker.sv
// Store-to-load forwarding checker (top).
// It judges one load per cycle against the slots of the store queue and
// registers the verdict, which gives a fixed one-cycle latency. It also
// keeps the oldest partial-overlap stall and the oldest cache-blocked load.
// Assumptions: sequence numbers do not wrap while compared; SQ_DEPTH is a
// power of two; req_size lies in 1..DATA_BYTES.
module stlf_checker
    import stlf_pkg::*;
#(
    parameter int SQ_DEPTH   = 8,
    parameter int LQ_DEPTH   = 8,
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 8,
    parameter int SEQ_W      = 16,
    localparam int PTR_W     = $clog2(SQ_DEPTH),
    localparam int LQ_W      = $clog2(LQ_DEPTH),
    localparam int SZ_W      = $clog2(DATA_BYTES) + 1,
    localparam int DW        = DATA_BYTES * 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [SZ_W-1:0]          req_size,
    input  logic [PTR_W-1:0]         req_sq_idx,
    input  logic [LQ_W-1:0]          req_lq_idx,
    input  logic [SEQ_W-1:0]         req_seq,
    input  logic                     req_uncache,
    input  logic                     req_at_commit,
    input  logic [LQ_W-1:0]          lq_head,
    input  logic [PTR_W-1:0]         sq_wb_ptr,
    input  logic [SQ_DEPTH*ADDR_W-1:0] sq_addr,
    input  logic [SQ_DEPTH*SZ_W-1:0] sq_size,
    input  logic [SQ_DEPTH*DW-1:0]   sq_data,
    input  logic [SQ_DEPTH*SEQ_W-1:0] sq_seq,
    input  logic [SQ_DEPTH-1:0]      sq_uncache,
    input  logic                     cache_blocked,
    input  logic                     stall_release,
    input  logic                     blk_release,
    output logic                     fwd_valid,
    output logic [DW-1:0]            fwd_data,
    output logic                     replay_valid,
    output logic                     replay_partial,
    output logic [SEQ_W-1:0]         replay_store_seq,
    output logic                     mem_req_valid,
    output logic [ADDR_W-1:0]        mem_req_addr,
    output logic [SZ_W-1:0]          mem_req_size,
    output logic                     miss_refused,
    output logic                     stalled,
    output logic [SEQ_W-1:0]         stall_store_seq,
    output logic [LQ_W-1:0]          stall_load_idx,
    output logic                     ld_blocked,
    output logic [SEQ_W-1:0]         ld_blocked_seq
);

    logic [SQ_DEPTH-1:0] hit_full;
    logic [SQ_DEPTH-1:0] hit_part;
    scan_kind_e          kind;
    logic [PTR_W-1:0]    hit_idx;
    logic [DW-1:0]       sel_data;
    logic [SZ_W-1:0]     sel_size;
    logic [SEQ_W-1:0]    sel_seq;
    logic [DW-1:0]       ext_data;
    logic [SEQ_W-1:0]    stall_load_seq;

    logic uc_ok, go_fwd, go_part, go_uc, go_mem, go_ref;
    logic stall_live, stall_take, blk_live, blk_take;

    // One comparator per store slot.
    for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_cmp
        stlf_overlap #(
            .ADDR_W(ADDR_W),
            .SZ_W  (SZ_W)
        ) u_cmp (
            .ld_addr   (req_addr),
            .ld_size   (req_size),
            .st_addr   (sq_addr[g*ADDR_W +: ADDR_W]),
            .st_size   (sq_size[g*SZ_W +: SZ_W]),
            .st_uncache(sq_uncache[g]),
            .full      (hit_full[g]),
            .part      (hit_part[g])
        );
    end

    stlf_select #(
        .SQ_DEPTH(SQ_DEPTH),
        .PTR_W   (PTR_W)
    ) u_sel (
        .full   (hit_full),
        .part   (hit_part),
        .sq_idx (req_sq_idx),
        .wb_ptr (sq_wb_ptr),
        .kind   (kind),
        .hit_idx(hit_idx)
    );

    // Read port of the store queue: fields of the deciding slot.
    always_comb begin
        sel_data = '0;
        sel_size = '0;
        sel_seq  = '0;
        for (int e = 0; e < SQ_DEPTH; e++) begin
            if (PTR_W'(e) == hit_idx) begin
                sel_data = sq_data[e*DW +: DW];
                sel_size = sq_size[e*SZ_W +: SZ_W];
                sel_seq  = sq_seq[e*SEQ_W +: SEQ_W];
            end
        end
    end

    stlf_extract #(
        .ADDR_W    (ADDR_W),
        .DATA_BYTES(DATA_BYTES),
        .SZ_W      (SZ_W)
    ) u_ext (
        .st_data(sel_data),
        .st_size(sel_size),
        .ld_addr(req_addr),
        .ld_size(req_size),
        .data   (ext_data)
    );

    // Verdict decode, including the uncacheable head-and-commit gate.
    always_comb begin
        uc_ok      = !req_uncache || ((req_lq_idx == lq_head) && req_at_commit);
        go_uc      = req_valid && !uc_ok;
        go_fwd     = req_valid && uc_ok && (kind == SCAN_FULL);
        go_part    = req_valid && uc_ok && (kind == SCAN_PART);
        go_mem     = req_valid && uc_ok && (kind == SCAN_MISS) && !cache_blocked;
        go_ref     = req_valid && uc_ok && (kind == SCAN_MISS) && cache_blocked;
        stall_live = stalled && !stall_release;
        stall_take = go_part && (!stall_live || (req_seq < stall_load_seq));
        blk_live   = ld_blocked && !blk_release;
        blk_take   = go_ref && !(blk_live && (ld_blocked_seq < req_seq));
    end

    // Response registers: the fixed one-cycle verdict latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid        <= 1'b0;
            fwd_data         <= '0;
            replay_valid     <= 1'b0;
            replay_partial   <= 1'b0;
            replay_store_seq <= '0;
            mem_req_valid    <= 1'b0;
            mem_req_addr     <= '0;
            mem_req_size     <= '0;
            miss_refused     <= 1'b0;
        end else begin
            fwd_valid        <= go_fwd;
            fwd_data         <= go_fwd ? ext_data : '0;
            replay_valid     <= go_uc || go_part;
            replay_partial   <= go_part;
            replay_store_seq <= go_part ? sel_seq : '0;
            mem_req_valid    <= go_mem;
            mem_req_addr     <= go_mem ? req_addr : '0;
            mem_req_size     <= go_mem ? req_size : '0;
            miss_refused     <= go_ref;
        end
    end

    // Stall record: the oldest load replayed for a partial overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stalled         <= 1'b0;
            stall_store_seq <= '0;
            stall_load_idx  <= '0;
            stall_load_seq  <= '0;
        end else if (stall_take) begin
            stalled         <= 1'b1;
            stall_store_seq <= sel_seq;
            stall_load_idx  <= req_lq_idx;
            stall_load_seq  <= req_seq;
        end else if (stall_release) begin
            stalled         <= 1'b0;
            stall_store_seq <= '0;
            stall_load_idx  <= '0;
            stall_load_seq  <= '0;
        end
    end

    // Blocked record: the oldest load that found the cache blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_blocked     <= 1'b0;
            ld_blocked_seq <= '0;
        end else if (blk_take) begin
            ld_blocked     <= 1'b1;
            ld_blocked_seq <= req_seq;
        end else if (blk_release) begin
            ld_blocked     <= 1'b0;
            ld_blocked_seq <= '0;
        end
    end

endmodule

// File: rtl/stlf_checker_sva.sv
// Port-level properties of the forwarding checker, attached by bind.
// It assumes the synchronous active-low reset of the top module.
module stlf_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic cache_blocked,
    input logic stall_release,
    input logic fwd_valid,
    input logic replay_valid,
    input logic replay_partial,
    input logic mem_req_valid,
    input logic miss_refused,
    input logic stalled,
    input logic ld_blocked
);

    // At most one verdict is ever visible.
    assert_one_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, replay_valid, mem_req_valid, miss_refused}));

    // An accepted request gets a verdict in the next cycle.
    assert_req_answered_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rst_n) |=> ($countones({fwd_valid, replay_valid, mem_req_valid, miss_refused}) == 1));

    // No request, no verdict.
    assert_idle_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && rst_n) |=> !(fwd_valid || replay_valid || mem_req_valid || miss_refused));

    // A partial-overlap replay leaves a stall recorded.
    assert_partial_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (replay_valid && replay_partial) |-> stalled);

    // The stall record clears only on release.
    assert_stall_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stalled) |-> $past(stall_release));

    // A cache request never follows a blocked cache.
    assert_mem_when_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(!cache_blocked));

    // A refused miss leaves a blocked load recorded.
    assert_refused_recorded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_refused |-> ld_blocked);

endmodule

bind stlf_checker stlf_checker_sva u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .cache_blocked (cache_blocked),
    .stall_release (stall_release),
    .fwd_valid     (fwd_valid),
    .replay_valid  (replay_valid),
    .replay_partial(replay_partial),
    .mem_req_valid (mem_req_valid),
    .miss_refused  (miss_refused),
    .stalled       (stalled),
    .ld_blocked    (ld_blocked)
);

// File: tb/stlf_checker_tb.sv
module stlf_checker_tb;

    localparam int D  = 8;
    localparam int AW = 16;
    localparam int DB = 8;
    localparam int SW = 16;
    localparam int PW = 3;
    localparam int LW = 3;
    localparam int ZW = 4;
    localparam int DW = DB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [ZW-1:0] req_size = '0;
    logic [PW-1:0] req_sq_idx = '0;
    logic [LW-1:0] req_lq_idx = '0;
    logic [SW-1:0] req_seq = '0;
    logic req_uncache = 1'b0;
    logic req_at_commit = 1'b0;
    logic [LW-1:0] lq_head = '0;
    logic [PW-1:0] sq_wb_ptr = '0;
    logic [D*AW-1:0] sq_addr;
    logic [D*ZW-1:0] sq_size;
    logic [D*DW-1:0] sq_data;
    logic [D*SW-1:0] sq_seq;
    logic [D-1:0] sq_uncache;
    logic cache_blocked = 1'b0;
    logic stall_release = 1'b0;
    logic blk_release = 1'b0;
    logic fwd_valid, replay_valid, replay_partial, mem_req_valid, miss_refused;
    logic stalled, ld_blocked;
    logic [DW-1:0] fwd_data;
    logic [SW-1:0] replay_store_seq, stall_store_seq, ld_blocked_seq;
    logic [AW-1:0] mem_req_addr;
    logic [ZW-1:0] mem_req_size;
    logic [LW-1:0] stall_load_idx;

    // Bench copy of the store queue.
    logic [AW-1:0] m_addr [D];
    logic [ZW-1:0] m_size [D];
    logic [DW-1:0] m_data [D];
    logic [SW-1:0] m_seq  [D];
    logic          m_uc   [D];

    // Reference state.
    logic          m_stalled = 1'b0;
    logic [SW-1:0] m_sseq = '0;
    logic [LW-1:0] m_slidx = '0;
    logic [SW-1:0] m_slseq = '0;
    logic          m_blk = 1'b0;
    logic [SW-1:0] m_bseq = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string ctx = "";

    always #10 clk = ~clk;

    stlf_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_sq_idx(req_sq_idx), .req_lq_idx(req_lq_idx),
        .req_seq(req_seq), .req_uncache(req_uncache), .req_at_commit(req_at_commit),
        .lq_head(lq_head), .sq_wb_ptr(sq_wb_ptr), .sq_addr(sq_addr), .sq_size(sq_size),
        .sq_data(sq_data), .sq_seq(sq_seq), .sq_uncache(sq_uncache),
        .cache_blocked(cache_blocked), .stall_release(stall_release),
        .blk_release(blk_release), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .replay_valid(replay_valid), .replay_partial(replay_partial),
        .replay_store_seq(replay_store_seq), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .miss_refused(miss_refused), .stalled(stalled), .stall_store_seq(stall_store_seq),
        .stall_load_idx(stall_load_idx), .ld_blocked(ld_blocked),
        .ld_blocked_seq(ld_blocked_seq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] act=%h exp=%h", tag, ctx, act, exp);
        end
    endtask

    task automatic pack();
        for (int j = 0; j < D; j++) begin
            sq_addr[j*AW +: AW] = m_addr[j];
            sq_size[j*ZW +: ZW] = m_size[j];
            sq_data[j*DW +: DW] = m_data[j];
            sq_seq[j*SW +: SW]  = m_seq[j];
            sq_uncache[j]       = m_uc[j];
        end
    endtask

    // Reference scan: 0 miss, 1 contains, 2 partial; idx is the deciding slot.
    task automatic ref_scan(output int kind, output int idx);
        int span;
        int ls, le, ss, se;
        kind = 0;
        idx = 0;
        span = (int'(req_sq_idx) - int'(sq_wb_ptr) + D) % D;
        ls = int'(req_addr);
        le = ls + int'(req_size);
        for (int k = 0; k < span; k++) begin
            int j;
            j = (int'(req_sq_idx) - 1 - k + D) % D;
            ss = int'(m_addr[j]);
            se = ss + int'(m_size[j]);
            if (kind == 0 && m_size[j] != 0 && !m_uc[j] && ls < se && le > ss) begin
                kind = (ls >= ss && le <= se) ? 1 : 2;
                idx = j;
            end
        end
    endtask

    function automatic logic [DW-1:0] ref_bytes(input int j);
        logic [DW-1:0] r;
        int off;
        r = '0;
        off = int'(req_addr) % int'(m_size[j]);
        for (int i = 0; i < int'(req_size); i++) begin
            if (off + i < DB) r[i*8 +: 8] = m_data[j][(off+i)*8 +: 8];
        end
        return r;
    endfunction

    // One clock: apply inputs, sample at the falling edge, compare with the reference.
    task automatic step();
        int kind, idx;
        bit e_fwd, e_rep, e_part, e_mem, e_ref, uc_ok, live;
        string tag;
        pack();
        @(posedge clk);
        @(negedge clk);
        e_fwd = 0; e_rep = 0; e_part = 0; e_mem = 0; e_ref = 0;
        kind = 0; idx = 0;
        tag = "R11";
        uc_ok = !req_uncache || (req_lq_idx == lq_head && req_at_commit);
        if (req_valid) begin
            if (!uc_ok) begin
                e_rep = 1; tag = "R8";
            end else begin
                ref_scan(kind, idx);
                if (kind == 1) begin e_fwd = 1; tag = "R4"; end
                else if (kind == 2) begin e_rep = 1; e_part = 1; tag = "R6"; end
                else if (cache_blocked) begin e_ref = 1; tag = "R10"; end
                else begin e_mem = 1; tag = "R9"; end
            end
        end
        chk({fwd_valid, replay_valid, mem_req_valid, miss_refused} == {e_fwd, e_rep, e_mem, e_ref},
            tag, {fwd_valid, replay_valid, mem_req_valid, miss_refused},
            {e_fwd, e_rep, e_mem, e_ref});
        if (e_fwd) chk(fwd_data == ref_bytes(idx), "R5", fwd_data, ref_bytes(idx));
        if (e_rep) begin
            chk(replay_partial == e_part, tag, replay_partial, e_part);
            if (e_part) chk(replay_store_seq == m_seq[idx], "R6", replay_store_seq, m_seq[idx]);
        end
        if (e_mem) chk({mem_req_addr, mem_req_size} == {req_addr, req_size}, "R9",
                       {mem_req_addr, mem_req_size}, {req_addr, req_size});
        // Reference stall record.
        live = m_stalled && !stall_release;
        if (e_part && (!live || req_seq < m_slseq)) begin
            m_stalled = 1; m_sseq = m_seq[idx]; m_slidx = req_lq_idx; m_slseq = req_seq;
        end else if (stall_release) begin
            m_stalled = 0; m_sseq = '0; m_slidx = '0; m_slseq = '0;
        end
        chk({stalled, stall_store_seq, stall_load_idx} == {m_stalled, m_sseq, m_slidx}, "R7",
            {stalled, stall_store_seq, stall_load_idx}, {m_stalled, m_sseq, m_slidx});
        // Reference blocked record.
        live = m_blk && !blk_release;
        if (e_ref && !(live && m_bseq < req_seq)) begin
            m_blk = 1; m_bseq = req_seq;
        end else if (blk_release) begin
            m_blk = 0; m_bseq = '0;
        end
        chk({ld_blocked, ld_blocked_seq} == {m_blk, m_bseq}, "R10",
            {ld_blocked, ld_blocked_seq}, {m_blk, m_bseq});
    endtask

    task automatic clear_sq();
        for (int j = 0; j < D; j++) begin
            m_addr[j] = '0; m_size[j] = '0; m_data[j] = '0; m_seq[j] = '0; m_uc[j] = 1'b0;
        end
    endtask

    task automatic put(input int j, input logic [AW-1:0] a, input int sz, input logic [DW-1:0] d,
                       input logic [SW-1:0] s, input bit uc);
        m_addr[j] = a; m_size[j] = ZW'(sz); m_data[j] = d; m_seq[j] = s; m_uc[j] = uc;
    endtask

    task automatic ld(input logic [AW-1:0] a, input int sz, input int sqi, input int lqi,
                      input logic [SW-1:0] s);
        req_valid = 1; req_addr = a; req_size = ZW'(sz); req_sq_idx = PW'(sqi);
        req_lq_idx = LW'(lqi); req_seq = s; req_uncache = 0; req_at_commit = 0;
        cache_blocked = 0; stall_release = 0; blk_release = 0;
    endtask

    function automatic int rsize(input bit allow_zero);
        int v;
        v = allow_zero ? int'($urandom % 5) : 1 + int'($urandom % 4);
        case (v)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 4;
            default: return 8;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        clear_sq();
        pack();
        // R1: reset state.
        ctx = "R1 reset";
        req_valid = 1;
        repeat (3) @(negedge clk);
        chk({fwd_valid, replay_valid, mem_req_valid, miss_refused, stalled, ld_blocked} == 6'b0,
            "R1", {fwd_valid, replay_valid, mem_req_valid, miss_refused, stalled, ld_blocked}, 0);
        chk({fwd_data, replay_store_seq} == '0, "R1", fwd_data, 0);
        chk({mem_req_addr, stall_store_seq, ld_blocked_seq} == '0, "R1", mem_req_addr, 0);
        req_valid = 0;
        rst_n = 1;

        // R2: a slot just older than the writeback pointer is outside the window.
        ctx = "R2 outside window";
        sq_wb_ptr = 3'd2;
        put(1, 16'h0100, 8, 64'h1111_2222_3333_4444, 16'd10, 0);
        ld(16'h0100, 4, 4, 5, 16'd50);
        step();
        chk(mem_req_valid == 1'b1, "R2", mem_req_valid, 1);
        // R2: the slot at the writeback pointer is examined.
        ctx = "R2 slot at pointer";
        put(2, 16'h0100, 8, 64'h0807_0605_0403_0201, 16'd11, 0);
        step();
        chk(fwd_valid == 1'b1 && fwd_data == 64'h0403_0201, "R2", fwd_data, 64'h0403_0201);
        // R3: size-zero and uncacheable slots are passed over.
        ctx = "R3 size zero";
        put(3, 16'h0100, 0, 64'hdead_beef_dead_beef, 16'd12, 0);
        step();
        chk(fwd_data == 64'h0403_0201, "R3", fwd_data, 64'h0403_0201);
        ctx = "R3 uncacheable store";
        put(3, 16'h0100, 8, 64'hdead_beef_dead_beef, 16'd12, 1);
        step();
        chk(fwd_data == 64'h0403_0201, "R3", fwd_data, 64'h0403_0201);
        // R4: youngest containing store wins.
        ctx = "R4 youngest";
        m_uc[3] = 0;
        step();
        chk(fwd_data == 64'hdead_beef, "R4", fwd_data, 64'hdead_beef);
        // R5: offset into a store's data.
        ctx = "R5 offset";
        put(3, 16'h0108, 8, 64'h8877_6655_4433_2211, 16'd13, 0);
        ld(16'h010A, 2, 4, 5, 16'd50);
        step();
        chk(fwd_data == 64'h4433, "R5", fwd_data, 64'h4433);
        // R6: partial overlap replays and records the stall.
        ctx = "R6 partial";
        ld(16'h0106, 4, 4, 5, 16'd50);
        step();
        chk(replay_store_seq == 16'd13, "R6", replay_store_seq, 16'd13);
        // R7: a younger stalled load does not take over; an older one does.
        ctx = "R7 younger keeps";
        ld(16'h0106, 4, 4, 6, 16'd60);
        step();
        chk(stall_load_idx == 3'd5, "R7", stall_load_idx, 5);
        ctx = "R7 older takes";
        ld(16'h0106, 4, 4, 2, 16'd40);
        step();
        chk(stall_load_idx == 3'd2, "R7", stall_load_idx, 2);
        ctx = "R7 release";
        req_valid = 0; stall_release = 1;
        step();
        chk(stalled == 1'b0, "R7", stalled, 0);
        // R8: an uncacheable load away from the head is turned back without a stall.
        ctx = "R8 away from head";
        ld(16'h0106, 4, 4, 1, 16'd30);
        req_uncache = 1; lq_head = 3'd0; req_at_commit = 1;
        step();
        chk(stalled == 1'b0 && replay_partial == 1'b0, "R8", {stalled, replay_partial}, 0);
        ctx = "R8 at head and commit";
        ld(16'h0100, 8, 4, 0, 16'd30);
        req_uncache = 1; lq_head = 3'd0; req_at_commit = 1;
        step();
        chk(fwd_valid == 1'b1, "R8", fwd_valid, 1);
        // R9: a miss goes to the cache.
        ctx = "R9 miss";
        ld(16'h0200, 4, 4, 0, 16'd70);
        step();
        chk(mem_req_addr == 16'h0200, "R9", mem_req_addr, 16'h0200);
        // R10: blocked cache; keep the oldest; release.
        ctx = "R10 blocked";
        cache_blocked = 1;
        step();
        ctx = "R10 younger keeps";
        req_seq = 16'd80;
        step();
        chk(ld_blocked_seq == 16'd70, "R10", ld_blocked_seq, 70);
        ctx = "R10 older takes";
        req_seq = 16'd65;
        step();
        chk(ld_blocked_seq == 16'd65, "R10", ld_blocked_seq, 65);
        ctx = "R10 release";
        req_valid = 0; blk_release = 1;
        step();
        chk(ld_blocked == 1'b0, "R10", ld_blocked, 0);
        // R11: idle cycle has no verdict.
        ctx = "R11 idle";
        blk_release = 0;
        step();

        // Random mix over a small address window so overlaps are frequent.
        ctx = "random";
        for (int n = 0; n < 1500; n++) begin
            if (n % 4 == 0) begin
                for (int j = 0; j < D; j++) begin
                    int sz;
                    logic [AW-1:0] a;
                    sz = rsize(1);
                    a = 16'h0100 + AW'($urandom % 32);
                    if (sz > 1) a = a & ~AW'(sz - 1);
                    put(j, a, sz, {$urandom, $urandom}, SW'($urandom % 200), ($urandom % 8) == 0);
                end
            end
            begin
                int sz;
                logic [AW-1:0] a;
                sz = rsize(0);
                a = 16'h0100 + AW'($urandom % 32);
                if (sz > 1) a = a & ~AW'(sz - 1);
                req_valid = ($urandom % 8) != 0;
                req_addr = a;
                req_size = ZW'(sz);
                req_sq_idx = PW'($urandom);
                sq_wb_ptr = PW'($urandom);
                req_lq_idx = LW'($urandom);
                lq_head = LW'($urandom % 2);
                req_seq = SW'($urandom % 200);
                req_uncache = ($urandom % 6) == 0;
                req_at_commit = $urandom % 2;
                cache_blocked = ($urandom % 4) == 0;
                stall_release = ($urandom % 6) == 0;
                blk_release = ($urandom % 6) == 0;
            end
            step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule